// File: doc/BRIEF.md
# Stream-to-Memory Receive DMA Channel

This block is a single receive channel of a descriptor-driven DMA engine. A producer hands it a byte stream over a valid/ready interface, with a `last` flag marking the final byte of a packet. The channel stores those bytes into memory buffers described by a linked list of descriptors. Each descriptor is four 32-bit words at consecutive word addresses: the link to the next descriptor at +0, the buffer start address at +4, a flag word at +8, and the address one past the buffer's final byte at +12.

Software, or a neighbouring block, points the channel at the first descriptor with a one-cycle start pulse. The channel fetches that descriptor and fills its buffer. A buffer is closed for one of two reasons: it is full, or the packet ends before it is full. On closing, the channel rewrites the descriptor's end address with the real fill position and sets an input end-of-packet flag when the packet ended. It writes the descriptor back, pulses interrupt-set bits, and then either follows the link or halts at end-of-list.

Incoming bytes are packed into 32-bit memory writes with byte enables. Interrupt masking and register decoding belong to the surrounding logic. The channel only reports which interrupt bits to set.

Top module: `rxdma_rx_channel`

## Requirements
- R1: A pulse on `start_i` in the idle or halted state makes the channel read the four descriptor words at `start_addr_i`, +4, +8 and +12, in that order. It then raises `s_ready_o`, with the fill position set to the buffer start taken from word +4.
- R2: Each accepted byte goes to the current fill position: word address = position with its two low bits cleared, byte-enable bit = position[1:0], little-endian lanes. A word is written when its highest lane has been filled or when the buffer closes, carrying only the lanes that were filled.
- R3: A buffer closes when the fill position reaches the end address from word +12. The next byte goes to the following buffer.
- R4: A byte with `s_last_i` set closes the buffer at once. The write-back of word +8 is the fetched flag word with bit 11 set. The write-back of word +12 is the address just past the last stored byte.
- R5: On every close, any partial data word is written first, then word +8, then word +12. Only after that is any further descriptor read issued.
- R6: When a close's write-back completes, `irq_set_o` pulses for exactly one cycle. Bits 0 and 1 are set together when flag bit 4 of the descriptor is set, bit 3 is set when the close came from `s_last_i`, and bit 2 is always zero. When none of these bits apply, no pulse appears, and `irq_set_o` is zero at all other times.
- R7: When flag bit 0 (end-of-list) is set, the channel halts after the write-back. In the halted state `eol_o` is high, `s_ready_o` stays low (no bytes are taken) and no memory request is issued, until the next `start_i`.
- R8: When flag bit 0 is clear, the channel reads the descriptor at the link address from word +0 and continues filling from its buffer start.
- R9: A descriptor whose buffer start equals its end address is closed immediately, without taking a byte. Its word +8 is written back unchanged and its word +12 equals the start address.
- R10: A memory request (`mem_req_o`) keeps its address, direction and write data stable until the cycle in which `mem_ack_i` is high. Read data is taken in that cycle.
- R11: After reset, `s_ready_o`, `mem_req_o` and `eol_o` are low and `irq_set_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load descriptor at `start_addr_i` and run |
| start_addr_i | input | AW | Byte address of first descriptor |
| s_valid_i | input | 1 | Stream byte valid |
| s_data_i | input | 8 | Stream byte |
| s_last_i | input | 1 | Final byte of a packet |
| s_ready_o | output | 1 | Channel takes the offered byte |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | DW | Write data |
| mem_be_o | output | DW/8 | Write byte enables |
| mem_ack_i | input | 1 | Request completes this cycle |
| mem_rdata_i | input | DW | Read data, valid with `mem_ack_i` |
| irq_set_o | output | 4 | One-cycle interrupt-set bits on close |
| eol_o | output | 1 | Channel halted at end-of-list |

## Verification
The bench builds the channel with a 10-bit address space, so that a 1 KiB memory model holds every descriptor and buffer. The memory model acknowledges after a delay that cycles through 0, 1 and 2 wait cycles. This exposes the hold-until-acknowledge behaviour on reads, data flushes and write-backs alike. The descriptor chain places buffers at aligned and unaligned starts, with lengths of zero, two, four, six and ten bytes. This reaches full-buffer closes, early packet ends, a close that is both full and end-of-packet, and partial words at both the head and the tail of a buffer.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RUN,
      ST_FLUSH,
      ST_WB_FLG,
      ST_WB_END,
      ST_HALT
   } rx_state_e;

   // descriptor flag bit positions (shared with the transmit side)
   localparam int FLG_EOL    = 0;
   localparam int FLG_INTR   = 4;
   localparam int FLG_IN_EOP = 11;

   // descriptor word indices
   localparam int DW_NEXT = 0;
   localparam int DW_BUF  = 1;
   localparam int DW_FLG  = 2;
   localparam int DW_END  = 3;

   // interrupt-set bit positions
   localparam int IRQ_W     = 4;
   localparam int IRQ_DATA0 = 0;
   localparam int IRQ_DATA1 = 1;
   localparam int IRQ_EOP   = 3;

endpackage

// File: rtl/rxdma_packer.sv
module rxdma_packer #(
   parameter int DW = 32
) (
   input  logic                        clk_i,
   input  logic                        rst_ni,
   input  logic                        clr_i,
   input  logic                        put_i,
   input  logic [$clog2(DW/8)-1:0]     lane_i,
   input  logic [7:0]                  byte_i,
   output logic [DW-1:0]               word_o,
   output logic [DW/8-1:0]             be_o
);
   localparam int LANES = DW / 8;

   if (DW % 8 != 0 || LANES < 2) begin : g_bad_width
      $error("rxdma_packer: DW must be a multiple of 8 with at least two lanes");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [7:0] data_q;
      logic       en_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            data_q <= '0;
            en_q   <= 1'b0;
         end else if (put_i && lane_i == l) begin
            data_q <= byte_i;
            en_q   <= 1'b1;
         end else if (clr_i) begin
            en_q   <= 1'b0;
         end
      end
      assign word_o[8*l +: 8] = data_q;
      assign be_o[l]          = en_q;
   end

   // R2: a flush leaves no stale lane enabled
   a_r2_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i && !put_i |=> be_o == '0);

endmodule

// File: rtl/rxdma_desc.sv
module rxdma_desc
   import rxdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           ld_i,
   input  logic [1:0]     ld_idx_i,
   input  logic [DW-1:0]  ld_word_i,
   input  logic           wb_end_i,
   input  logic           wb_eop_i,
   input  logic [AW-1:0]  wb_pos_i,
   output logic [AW-1:0]  next_o,
   output logic [AW-1:0]  buf_o,
   output logic [DW-1:0]  flags_o,
   output logic [AW-1:0]  end_o,
   output logic [DW-1:0]  wb_word_o
);
   if (AW > DW) begin : g_bad_aw
      $error("rxdma_desc: AW must not exceed DW");
   end
   if (DW <= FLG_IN_EOP) begin : g_bad_dw
      $error("rxdma_desc: DW too narrow for the flag word");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         next_o  <= '0;
         buf_o   <= '0;
         flags_o <= '0;
         end_o   <= '0;
      end else if (ld_i) begin
         case (ld_idx_i)
            2'(DW_NEXT): next_o  <= ld_word_i[AW-1:0];
            2'(DW_BUF):  buf_o   <= ld_word_i[AW-1:0];
            2'(DW_FLG):  flags_o <= ld_word_i;
            default:     end_o   <= ld_word_i[AW-1:0];
         endcase
      end
   end

   logic [DW-1:0] eop_mask;
   always_comb begin
      eop_mask             = '0;
      eop_mask[FLG_IN_EOP] = wb_eop_i;
      if (wb_end_i) wb_word_o = DW'(wb_pos_i);
      else          wb_word_o = flags_o | eop_mask;
   end

endmodule

// File: rtl/rxdma_rx_channel.sv
module rxdma_rx_channel
   import rxdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 start_i,
   input  logic [AW-1:0]        start_addr_i,
   input  logic                 s_valid_i,
   input  logic [7:0]           s_data_i,
   input  logic                 s_last_i,
   output logic                 s_ready_o,
   output logic                 mem_req_o,
   output logic                 mem_we_o,
   output logic [AW-1:0]        mem_addr_o,
   output logic [DW-1:0]        mem_wdata_o,
   output logic [DW/8-1:0]      mem_be_o,
   input  logic                 mem_ack_i,
   input  logic [DW-1:0]        mem_rdata_i,
   output logic [IRQ_W-1:0]     irq_set_o,
   output logic                 eol_o
);
   localparam int LANES = DW / 8;
   localparam int LW    = $clog2(LANES);

   if (DW != 32) begin : g_bad_dw
      $error("rxdma_rx_channel: descriptor words are 32 bits, DW must be 32");
   end
   if (AW < 4 || AW > DW) begin : g_bad_aw
      $error("rxdma_rx_channel: AW out of range");
   end

   rx_state_e           state_q;
   logic [1:0]          idx_q;
   logic [AW-1:0]       desc_q;
   logic [AW-1:0]       pos_q;
   logic [AW-1:0]       flush_addr_q;
   logic                closing_q;
   logic                eop_q;
   logic [IRQ_W-1:0]    irq_q;

   logic [AW-1:0]       d_next, d_buf, d_end;
   logic [DW-1:0]       d_flags, wb_word;
   logic [DW-1:0]       pk_word;
   logic [LANES-1:0]    pk_be;

   logic                at_end, take, ack_rd, flush_done;
   logic [AW-1:0]       pos_nx;
   logic [IRQ_W-1:0]    irq_pend;

   // ---------------------------------------------------------------
   // stream side
   assign at_end    = (pos_q == d_end);
   assign s_ready_o = (state_q == ST_RUN) && !at_end;
   assign take      = s_valid_i && s_ready_o;
   assign pos_nx    = pos_q + AW'(1);

   // ---------------------------------------------------------------
   // memory side
   assign mem_req_o = (state_q == ST_FETCH) || (state_q == ST_FLUSH) ||
                      (state_q == ST_WB_FLG) || (state_q == ST_WB_END);
   assign mem_we_o  = (state_q != ST_FETCH);
   assign ack_rd    = (state_q == ST_FETCH) && mem_ack_i;
   assign flush_done = (state_q == ST_FLUSH) && mem_ack_i;

   always_comb begin
      case (state_q)
         ST_FETCH:  mem_addr_o = desc_q + (AW'(idx_q) << 2);
         ST_FLUSH:  mem_addr_o = flush_addr_q;
         ST_WB_FLG: mem_addr_o = desc_q + AW'(4 * DW_FLG);
         ST_WB_END: mem_addr_o = desc_q + AW'(4 * DW_END);
         default:   mem_addr_o = '0;
      endcase
      if (state_q == ST_FLUSH) begin
         mem_wdata_o = pk_word;
         mem_be_o    = pk_be;
      end else begin
         mem_wdata_o = wb_word;
         mem_be_o    = '1;
      end
   end

   always_comb begin
      irq_pend            = '0;
      irq_pend[IRQ_DATA0] = d_flags[FLG_INTR];
      irq_pend[IRQ_DATA1] = d_flags[FLG_INTR];
      irq_pend[IRQ_EOP]   = eop_q;
   end

   assign irq_set_o = irq_q;
   assign eol_o     = (state_q == ST_HALT);

   // ---------------------------------------------------------------
   // sub-blocks
   rxdma_desc #(.AW(AW), .DW(DW)) i_desc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ld_i      (ack_rd),
      .ld_idx_i  (idx_q),
      .ld_word_i (mem_rdata_i),
      .wb_end_i  (state_q == ST_WB_END),
      .wb_eop_i  (eop_q),
      .wb_pos_i  (pos_q),
      .next_o    (d_next),
      .buf_o     (d_buf),
      .flags_o   (d_flags),
      .end_o     (d_end),
      .wb_word_o (wb_word)
   );

   rxdma_packer #(.DW(DW)) i_packer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (flush_done),
      .put_i  (take),
      .lane_i (pos_q[LW-1:0]),
      .byte_i (s_data_i),
      .word_o (pk_word),
      .be_o   (pk_be)
   );

   // ---------------------------------------------------------------
   // control sequence
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q      <= ST_IDLE;
         idx_q        <= '0;
         desc_q       <= '0;
         pos_q        <= '0;
         flush_addr_q <= '0;
         closing_q    <= 1'b0;
         eop_q        <= 1'b0;
         irq_q        <= '0;
      end else begin
         irq_q <= '0;
         case (state_q)
            ST_IDLE, ST_HALT: begin
               if (start_i) begin
                  desc_q  <= start_addr_i;
                  idx_q   <= '0;
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (mem_ack_i) begin
                  idx_q <= idx_q + 2'd1;
                  if (idx_q == 2'(DW_END)) begin
                     pos_q     <= d_buf;
                     closing_q <= 1'b0;
                     eop_q     <= 1'b0;
                     state_q   <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               if (at_end) begin
                  closing_q <= 1'b1;
                  eop_q     <= 1'b0;
                  state_q   <= ST_WB_FLG;
               end else if (take) begin
                  pos_q        <= pos_nx;
                  flush_addr_q <= {pos_q[AW-1:LW], {LW{1'b0}}};
                  if (pos_nx == d_end || s_last_i) begin
                     closing_q <= 1'b1;
                     eop_q     <= s_last_i;
                     state_q   <= ST_FLUSH;
                  end else if (pos_nx[LW-1:0] == '0) begin
                     state_q   <= ST_FLUSH;
                  end
               end
            end
            ST_FLUSH: begin
               if (mem_ack_i) state_q <= closing_q ? ST_WB_FLG : ST_RUN;
            end
            ST_WB_FLG: begin
               if (mem_ack_i) state_q <= ST_WB_END;
            end
            ST_WB_END: begin
               if (mem_ack_i) begin
                  irq_q     <= irq_pend;
                  closing_q <= 1'b0;
                  if (d_flags[FLG_EOL]) begin
                     state_q <= ST_HALT;
                  end else begin
                     desc_q  <= d_next;
                     idx_q   <= '0;
                     state_q <= ST_FETCH;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // ---------------------------------------------------------------
   // checks
   a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));

   a_r3_pos_in_buffer: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_RUN |-> (pos_q - d_buf) <= (d_end - d_buf));

   a_r6_pair_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_set_o[IRQ_DATA0] == irq_set_o[IRQ_DATA1]);

   a_r6_after_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_set_o != '0 |-> $past(state_q == ST_WB_END && mem_ack_i));

   a_r7_halt_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      eol_o |-> !mem_req_o && !s_ready_o);

   a_r2_flush_has_bytes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_FLUSH |-> mem_be_o != '0);

endmodule

// File: tb/test_rxdma_rx_channel.sv
module test_rxdma_rx_channel;
   localparam int AW = 10;
   localparam int DW = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [AW-1:0]  start_addr = '0;
   logic           s_valid = 1'b0;
   logic [7:0]     s_data = '0;
   logic           s_last = 1'b0;
   logic           s_ready;
   logic           mem_req, mem_we, mem_ack = 1'b0;
   logic [AW-1:0]  mem_addr;
   logic [DW-1:0]  mem_wdata, mem_rdata = '0;
   logic [3:0]     mem_be;
   logic [3:0]     irq_set;
   logic           eol;

   always #5 clk = ~clk;

   rxdma_rx_channel #(.AW(AW), .DW(DW)) i_rxdma_rx_channel (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .start_addr_i(start_addr),
      .s_valid_i(s_valid), .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_ack_i(mem_ack),
      .mem_rdata_i(mem_rdata), .irq_set_o(irq_set), .eol_o(eol));

   int total = 0, bad = 0;
   bit done = 0;
   logic [7:0] mem [0:1023];

   logic [17:0] exp_wr[$];
   string       exp_wr_tag[$];
   logic [AW-1:0] exp_rd[$];
   string       exp_rd_tag[$];
   logic [3:0]  exp_irq[$];

   // bench model of the channel
   logic [AW-1:0] m_desc, m_pos, m_end;
   bit            m_eol = 0;

   task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] rd32(logic [AW-1:0] a);
      return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
   endfunction

   task automatic wr32(logic [AW-1:0] a, logic [31:0] w);
      for (int i = 0; i < 4; i++) mem[a+AW'(i)] = w[8*i +: 8];
   endtask

   task automatic exp_word(logic [AW-1:0] a, logic [31:0] w, string tag);
      for (int i = 0; i < 4; i++) begin
         exp_wr.push_back({a + AW'(i), w[8*i +: 8]});
         exp_wr_tag.push_back(tag);
      end
   endtask

   task automatic model_load(logic [AW-1:0] a, string tag);
      m_desc = a;
      for (int i = 0; i < 4; i++) begin
         exp_rd.push_back(a + AW'(4*i));
         exp_rd_tag.push_back(tag);
      end
      m_pos = rd32(a + 4)[AW-1:0];
      m_end = rd32(a + 12)[AW-1:0];
      if (m_pos == m_end) model_close(1'b0, "R9");
   endtask

   task automatic model_close(bit eop, string tag);
      logic [31:0] fl;
      logic [3:0]  iv;
      fl = rd32(m_desc + 8);
      exp_word(m_desc + 8, fl | (32'(eop) << 11), eop ? "R4" : tag);
      exp_word(m_desc + 12, 32'(m_pos), eop ? "R4" : tag);
      iv = {eop, 1'b0, fl[4], fl[4]};
      if (iv != 0) exp_irq.push_back(iv);
      if (fl[0]) m_eol = 1;
      else model_load(rd32(m_desc)[AW-1:0], "R8");
   endtask

   task automatic start(logic [AW-1:0] a);
      @(negedge clk);
      start_i = 1'b1;
      start_addr = a;
      m_eol = 0;
      model_load(a, "R1");
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic send(logic [7:0] b, bit last);
      if (m_eol) begin
         @(negedge clk);
         s_valid = 1'b1; s_data = b; s_last = last;
         for (int i = 0; i < 6; i++) begin
            chk(!s_ready && !mem_req, "R7", "byte taken or memory busy while halted",
                {s_ready, mem_req}, 0);
            @(negedge clk);
         end
         s_valid = 1'b0; s_last = 1'b0;
         return;
      end
      exp_wr.push_back({m_pos, b});
      exp_wr_tag.push_back("R2");
      m_pos = m_pos + 1;
      if (last) model_close(1'b1, "R4");
      else if (m_pos == m_end) model_close(1'b0, "R3");
      @(negedge clk);
      s_valid = 1'b1; s_data = b; s_last = last;
      while (!s_ready) @(negedge clk);
      @(negedge clk);
      s_valid = 1'b0; s_last = 1'b0;
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 2000; i++) begin
         if (exp_wr.size() == 0 && exp_rd.size() == 0 && exp_irq.size() == 0) break;
         @(negedge clk);
      end
      repeat (8) @(negedge clk);
      chk(exp_wr.size() == 0 && exp_rd.size() == 0 && exp_irq.size() == 0, tag,
          "outstanding expected items", exp_wr.size() + exp_rd.size() + exp_irq.size(), 0);
   endtask

   // memory model and monitor
   int  lat = 0, waitc = 0;
   bit  pend = 0;
   logic [AW-1:0] pend_addr;
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq_set != 0) begin
            if (exp_irq.size() == 0) chk(0, "R6", "unexpected interrupt pulse", 32'(irq_set), 0);
            else begin
               logic [3:0] e;
               e = exp_irq.pop_front();
               chk(irq_set == e, "R6", "interrupt bits", 32'(irq_set), 32'(e));
            end
         end
         if (pend && mem_req)
            chk(mem_addr == pend_addr, "R10", "address changed while waiting",
                32'(mem_addr), 32'(pend_addr));
         if (mem_ack) begin
            mem_ack = 1'b0;
            pend = 0;
         end else if (mem_req) begin
            if (waitc < lat) begin
               waitc++;
               pend = 1;
               pend_addr = mem_addr;
            end else begin
               waitc = 0;
               lat = (lat + 1) % 3;
               mem_ack = 1'b1;
               pend = 0;
               if (mem_we) begin
                  for (int i = 0; i < 4; i++) begin
                     if (mem_be[i]) begin
                        logic [17:0] got;
                        got = {mem_addr + AW'(i), mem_wdata[8*i +: 8]};
                        mem[mem_addr + AW'(i)] = mem_wdata[8*i +: 8];
                        if (exp_wr.size() == 0)
                           chk(0, "R5", "unexpected write {addr,byte}", 32'(got), 0);
                        else begin
                           logic [17:0] e;
                           string t;
                           e = exp_wr.pop_front();
                           t = exp_wr_tag.pop_front();
                           chk(got == e, t, "write {addr,byte}", 32'(got), 32'(e));
                        end
                     end
                  end
               end else begin
                  mem_rdata = rd32(mem_addr);
                  if (exp_rd.size() == 0)
                     chk(0, "R1", "unexpected read", 32'(mem_addr), 0);
                  else begin
                     logic [AW-1:0] e;
                     string t;
                     e = exp_rd.pop_front();
                     t = exp_rd_tag.pop_front();
                     chk(mem_addr == e, t, "read address", 32'(mem_addr), 32'(e));
                  end
               end
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      // chain: full close with intr, early end unaligned, zero length, full+last with eol
      wr32(10'h100, 32'h120); wr32(10'h104, 32'h200); wr32(10'h108, 32'h10); wr32(10'h10C, 32'h206);
      wr32(10'h120, 32'h140); wr32(10'h124, 32'h302); wr32(10'h128, 32'h0);  wr32(10'h12C, 32'h30C);
      wr32(10'h140, 32'h160); wr32(10'h144, 32'h380); wr32(10'h148, 32'h0);  wr32(10'h14C, 32'h380);
      wr32(10'h160, 32'h100); wr32(10'h164, 32'h3A0); wr32(10'h168, 32'h11); wr32(10'h16C, 32'h3A4);
      wr32(10'h180, 32'h0);   wr32(10'h184, 32'h3C1); wr32(10'h188, 32'h01); wr32(10'h18C, 32'h3C3);

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!s_ready, "R11", "ready after reset", 32'(s_ready), 0);
      chk(!mem_req, "R11", "request after reset", 32'(mem_req), 0);
      chk(!eol, "R11", "eol after reset", 32'(eol), 0);
      chk(irq_set == 0, "R11", "irq after reset", 32'(irq_set), 0);

      start(10'h100);
      for (int i = 0; i < 6; i++) send(8'hA0 + 8'(i), 1'b0);
      for (int i = 0; i < 3; i++) send(8'hB0 + 8'(i), i == 2);
      for (int i = 0; i < 4; i++) send(8'hC0 + 8'(i), i == 3);
      drain("R5");
      chk(eol, "R7", "halt after end-of-list", 32'(eol), 1);
      send(8'hEE, 1'b1);
      chk(eol, "R7", "still halted", 32'(eol), 1);

      start(10'h180);
      send(8'hD1, 1'b0);
      send(8'hD2, 1'b0);
      drain("R5");
      chk(eol, "R7", "halt after restart chain", 32'(eol), 1);
      chk(rd32(10'h124) == 32'h302, "R4", "unused field untouched", rd32(10'h124), 32'h302);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule